// File: doc/BRIEF.md
# Core Standby and Clock-Select Controller

This block sits beside a processor core and decides which clock the core runs on and whether the core runs at all. A small register bus lets software turn a PLL on, move the core onto the PLL output once the PLL reports lock, power peripherals down with a mask, and force the external clock output pin low. The PLL itself is outside the block and appears only as a lock input.

Setting the standby flag puts the core to sleep. A few already-issued instructions drain first, and then the core clock enable falls. The interrupt logic and the PLL keep running during sleep. An individually enabled pending interrupt wakes the core, but only while the global interrupt enable is set. On wake-up the standby flag clears by itself, the core clock restarts, and a one-cycle vector strobe follows in the first running cycle. If the PLL loses lock while it drives the core, the core drops back to the reference clock at once and the select bit clears. All clock gating is retimed on the falling edge, so gated clocks never carry a truncated pulse.

Top module: `stby_clk_ctrl`

## Requirements
- R1: After reset, `core_clk_en` is 1, `clk_src` is 0 (reference clock), `pll_on` is 0, `periph_off` is 0, `clkout_hold` is 0, `irq_vec` is 0, and every register reads 0.
- R2: Register select 0 is the PLL control register. Bit 15 is the PLL enable and drives `pll_on`. Bit 14 reads the PLL select. Bit 13 is read-only and reads the `pll_lock` input.
- R3: A write to select 0 sets the PLL select only if the same write also sets bit 15 and `pll_lock` is 1 at that edge. Otherwise the select stays 0 and `clk_src` stays 0.
- R4: While the PLL is selected, a low `pll_lock` sends `clk_src` to 0 in the same cycle, and the select bit clears at the next edge. It stays clear when lock returns.
- R5: Writing 1 to bit 15 of register select 1 (the standby flag) sets the flag, which reads back at bit 15. `core_clk_en` stays 1 for DRAIN_CYC (default 3) more edges and is 0 after the DRAIN_CYC-th edge. Writing 0 to that bit has no effect.
- R6: While `core_clk_en` is 0, the gated clock `core_clk` stays low in its high phase. While running, `core_clk` follows `clk`.
- R7: While asleep, the core stays asleep if `irq_glob_en` is 0, or if no pending line in `irq_pend` is also set in `irq_en`.
- R8: At the first edge in sleep where `irq_glob_en` is 1 and some bit of `irq_pend & irq_en` is 1, `core_clk_en` rises, the standby flag clears, and `irq_vec` is 1 for exactly that one following cycle.
- R9: Register select 2 holds the peripheral power-down mask. It reads back at once, and `periph_off` takes the written value two edges after the write edge.
- R10: Bit 6 of register select 3 drives `clkout_hold`. While it is set, `clk_out` stays low from the next full high phase. Clearing it lets `clk_out` follow `clk` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 PLL, 1 flag, 2 power, 3 I/O) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational |
| pll_lock | input | 1 | Lock indication from the PLL |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_glob_en | input | 1 | Global interrupt enable |
| pll_on | output | 1 | PLL enable |
| clk_src | output | 1 | Core clock source, 1 = PLL |
| core_clk_en | output | 1 | Core clock enable |
| core_clk | output | 1 | Glitch-free gated core clock |
| irq_vec | output | 1 | One-cycle strobe to vector the waking interrupt |
| periph_off | output | PWR_W | Peripheral power-down mask after settling |
| clkout_hold | output | 1 | Clock output forced low |
| clk_out | output | 1 | Glitch-free clock output pin |

## Verification
The assertions take the bus as silent while the core sleeps, since a stopped core issues no writes. They also take reset as held for at least three cycles, so that the settling check on the power mask never looks back past reset. The lock input is taken as already synchronous to `clk`. The directed tests drive every input just after a falling edge. They write only while the core runs, and they hold reset for five cycles, so the stimulus stays within these limits.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
package stby_pkg;
    localparam int REG_W        = 16;
    localparam int PLL_EN_BIT   = 15;
    localparam int PLL_SEL_BIT  = 14;
    localparam int PLL_LOCK_BIT = 13;
    localparam int AWAIT_BIT    = 15;
    localparam int CKO_HOLD_BIT = 6;
    localparam int PWR_STAGES   = 2;

    typedef enum logic [1:0] {
        RS_PLL  = 2'd0,
        RS_FLAG = 2'd1,
        RS_PWR  = 2'd2,
        RS_IOC  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_SLEEP,
        ST_WAKE
    } stby_state_e;

    typedef struct packed {
        logic en;
        logic sel;
    } pll_ctrl_t;

    function automatic logic sel_hit(input logic wr, input logic [1:0] sel, input reg_sel_e target);
        return wr && (reg_sel_e'(sel) == target);
    endfunction
endpackage

// File: rtl/sc_pll_ctrl.sv
`timescale 1ns/1ps
module sc_pll_ctrl
    import stby_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic w_en,
    input  logic w_sel,
    input  logic lock,
    output logic pll_on,
    output logic sel_q,
    output logic clk_src
);
    pll_ctrl_t ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.en  <= w_en;
            ctrl.sel <= w_sel && w_en && lock;
        end else if (ctrl.sel && !lock) begin
            ctrl.sel <= 1'b0;
        end
    end

    assign pll_on  = ctrl.en;
    assign sel_q   = ctrl.sel;
    assign clk_src = ctrl.sel && lock;

    // R3: the select can only come up on a locked, enabled PLL
    a_r3_sel_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> $past(lock) && pll_on);

    // R4: lost lock drops the select at the next edge
    a_r4_lock_fallback: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !lock && !wr) |=> !sel_q);
endmodule

// File: rtl/sc_standby_fsm.sv
`timescale 1ns/1ps
module sc_standby_fsm
    import stby_pkg::*;
#(
    parameter int N_IRQ     = 8,
    parameter int DRAIN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_await,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_glob_en,
    output logic             await_q,
    output logic             core_clk_en,
    output logic             irq_vec
);
    localparam int CNT_W = (DRAIN_CYC < 2) ? 1 : $clog2(DRAIN_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYC - 1);

    stby_state_e state;
    logic [CNT_W-1:0] cnt;
    logic wake_req;

    assign wake_req = irq_glob_en && (|(irq_pend & irq_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: if (set_await) begin
                    state <= ST_DRAIN;
                    cnt   <= '0;
                end
                ST_DRAIN: if (cnt == CNT_LAST) state <= ST_SLEEP;
                          else cnt <= cnt + 1'b1;
                ST_SLEEP: if (wake_req) state <= ST_WAKE;
                default:  state <= ST_RUN;
            endcase
        end
    end

    assign await_q     = (state == ST_DRAIN) || (state == ST_SLEEP);
    assign core_clk_en = (state != ST_SLEEP);
    assign irq_vec     = (state == ST_WAKE);

    // R5: the clock keeps running through the drain
    a_r5_drain_runs: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && set_await) |=> core_clk_en && await_q);

    // R7: no qualified interrupt means the core stays asleep
    a_r7_stay_asleep: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake_req) |=> !core_clk_en && await_q);

    // R8: wake restarts the clock, clears the flag and vectors once
    a_r8_wake: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake_req) |=> core_clk_en && irq_vec && !await_q);

    a_r8_vec_single: assert property (@(posedge clk) disable iff (rst)
        irq_vec |=> !irq_vec);
endmodule

// File: rtl/sc_pwr_pipe.sv
`timescale 1ns/1ps
module sc_pwr_pipe
    import stby_pkg::*;
#(
    parameter int PWR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [PWR_W-1:0] wdata,
    output logic [PWR_W-1:0] mask_q,
    output logic [PWR_W-1:0] periph_off
);
    logic [PWR_W-1:0] stage [PWR_STAGES];

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (wr) mask_q <= wdata;
    end

    for (genvar s = 0; s < PWR_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stage[s] <= '0;
            else if (s == 0) stage[s] <= mask_q;
            else             stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
    end

    assign periph_off = stage[PWR_STAGES-1];

    // R9: the output follows the register after the settling stages
    a_r9_settle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> periph_off == $past(mask_q, PWR_STAGES));
endmodule

// File: rtl/sc_clk_gate.sv
`timescale 1ns/1ps
module sc_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gclk
);
    logic en_lo;

    always_ff @(negedge clk) begin
        if (rst) en_lo <= 1'b1;
        else     en_lo <= en;
    end

    assign gclk = clk && en_lo;
endmodule

// File: rtl/stby_clk_ctrl.sv
`timescale 1ns/1ps
module stby_clk_ctrl
    import stby_pkg::*;
#(
    parameter int N_IRQ     = 8,
    parameter int PWR_W     = 16,
    parameter int DRAIN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       rd_sel,
    output logic [15:0]      rd_data,
    input  logic             pll_lock,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_glob_en,
    output logic             pll_on,
    output logic             clk_src,
    output logic             core_clk_en,
    output logic             core_clk,
    output logic             irq_vec,
    output logic [PWR_W-1:0] periph_off,
    output logic             clkout_hold,
    output logic             clk_out
);
    localparam int N_GATES = 2;

    logic wr_pll, wr_flag, wr_pwr, wr_ioc;
    logic sel_q, await_q, hold_q;
    logic [PWR_W-1:0] mask_q;
    logic [N_GATES-1:0] gate_en, gate_out;

    assign wr_pll  = sel_hit(wr_en, wr_sel, RS_PLL);
    assign wr_flag = sel_hit(wr_en, wr_sel, RS_FLAG);
    assign wr_pwr  = sel_hit(wr_en, wr_sel, RS_PWR);
    assign wr_ioc  = sel_hit(wr_en, wr_sel, RS_IOC);

    sc_pll_ctrl u_pll (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_pll),
        .w_en    (wr_data[PLL_EN_BIT]),
        .w_sel   (wr_data[PLL_SEL_BIT]),
        .lock    (pll_lock),
        .pll_on  (pll_on),
        .sel_q   (sel_q),
        .clk_src (clk_src)
    );

    sc_standby_fsm #(.N_IRQ(N_IRQ), .DRAIN_CYC(DRAIN_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .set_await   (wr_flag && wr_data[AWAIT_BIT]),
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .irq_glob_en (irq_glob_en),
        .await_q     (await_q),
        .core_clk_en (core_clk_en),
        .irq_vec     (irq_vec)
    );

    sc_pwr_pipe #(.PWR_W(PWR_W)) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_pwr),
        .wdata      (wr_data[PWR_W-1:0]),
        .mask_q     (mask_q),
        .periph_off (periph_off)
    );

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= 1'b0;
        else if (wr_ioc) hold_q <= wr_data[CKO_HOLD_BIT];
    end
    assign clkout_hold = hold_q;

    assign gate_en = {~hold_q, core_clk_en};
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        sc_clk_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .en   (gate_en[g]),
            .gclk (gate_out[g])
        );
    end
    assign core_clk = gate_out[0];
    assign clk_out  = gate_out[1];

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            RS_PLL: begin
                rd_data[PLL_EN_BIT]   = pll_on;
                rd_data[PLL_SEL_BIT]  = sel_q;
                rd_data[PLL_LOCK_BIT] = pll_lock;
            end
            RS_FLAG: rd_data[AWAIT_BIT] = await_q;
            RS_PWR:  rd_data = REG_W'(mask_q);
            default: rd_data[CKO_HOLD_BIT] = hold_q;
        endcase
    end

    // R10: the hold bit tracks the last write to the I/O register
    a_r10_hold_write: assert property (@(posedge clk) disable iff (rst)
        wr_ioc |=> clkout_hold == $past(wr_data[CKO_HOLD_BIT]));

    // R2: PLL enable follows the last write to the PLL register
    a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
        wr_pll |=> pll_on == $past(wr_data[PLL_EN_BIT]));
endmodule

// File: tb/test_stby_clk_ctrl.sv
`timescale 1ns/1ps
module test_stby_clk_ctrl;
    localparam int N_IRQ = 8;
    localparam int PWR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [15:0] rd_data;
    logic pll_lock = 1'b0;
    logic [N_IRQ-1:0] irq_pend = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic irq_glob_en = 1'b0;
    logic pll_on, clk_src, core_clk_en, core_clk, irq_vec, clkout_hold, clk_out;
    logic [PWR_W-1:0] periph_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stby_clk_ctrl #(.N_IRQ(N_IRQ), .PWR_W(PWR_W), .DRAIN_CYC(3)) i_stby_clk_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pll_lock(pll_lock), .irq_pend(irq_pend),
        .irq_en(irq_en), .irq_glob_en(irq_glob_en), .pll_on(pll_on), .clk_src(clk_src),
        .core_clk_en(core_clk_en), .core_clk(core_clk), .irq_vec(irq_vec),
        .periph_off(periph_off), .clkout_hold(clkout_hold), .clk_out(clk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        rd_sel = s; #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int r = 0; r < 4; r++) begin
            rd(r[1:0], v);
            check("R1 register reads zero", 32'(v), 0);
        end
        check("R1 core_clk_en", 32'(core_clk_en), 1);
        check("R1 clk_src", 32'(clk_src), 0);
        check("R1 pll_on", 32'(pll_on), 0);
        check("R1 periph_off", 32'(periph_off), 0);
        check("R1 clkout_hold", 32'(clkout_hold), 0);
        check("R1 irq_vec", 32'(irq_vec), 0);
        @(posedge clk); #2;
        check("R6 core_clk follows clk when running", 32'(core_clk), 1);
    endtask

    task automatic t_pll;
        logic [15:0] v;
        wr(2'd0, 16'h8000);
        check("R2 pll_on after enable", 32'(pll_on), 1);
        wr(2'd0, 16'hC000);
        check("R3 select refused without lock", 32'(clk_src), 0);
        rd(2'd0, v);
        check("R3 select bit stays 0", 32'(v), 32'h8000);
        wr(2'd0, 16'h4000);
        check("R3 select refused, enable cleared", 32'(pll_on), 0);
        pll_lock = 1'b1;
        wr(2'd0, 16'h4000);
        check("R3 select refused without enable", 32'(clk_src), 0);
        wr(2'd0, 16'hC000);
        check("R3 select accepted when locked", 32'(clk_src), 1);
        rd(2'd0, v);
        check("R2 readback enable/select/lock", 32'(v), 32'hE000);
    endtask

    task automatic t_lock_loss;
        logic [15:0] v;
        pll_lock = 1'b0; #1;
        check("R4 immediate fallback", 32'(clk_src), 0);
        @(negedge clk); #1;
        rd(2'd0, v);
        check("R4 select cleared", 32'(v), 32'h8000);
        pll_lock = 1'b1;
        @(negedge clk); #1;
        check("R4 stays on reference after relock", 32'(clk_src), 0);
        wr(2'd0, 16'h0000);
        check("R2 pll_on after disable", 32'(pll_on), 0);
    endtask

    task automatic t_power;
        logic [15:0] v;
        wr(2'd2, 16'h181F);
        rd(2'd2, v);
        check("R9 mask reads back at once", 32'(v), 32'h181F);
        check("R9 not yet settled (1 edge)", 32'(periph_off), 0);
        @(negedge clk); #1;
        check("R9 not yet settled (2nd edge pending)", 32'(periph_off), 0);
        @(negedge clk); #1;
        check("R9 settled after two edges", 32'(periph_off), 32'h181F);
        wr(2'd2, 16'h0000);
        @(negedge clk); #1;
        check("R9 power-up not yet settled", 32'(periph_off), 32'h181F);
        @(negedge clk); #1;
        check("R9 power-up settled", 32'(periph_off), 0);
    endtask

    task automatic t_clkout;
        wr(2'd3, 16'h0040);
        check("R10 hold bit set", 32'(clkout_hold), 1);
        @(posedge clk); #2;
        check("R10 clk_out low in high phase", 32'(clk_out), 0);
        wr(2'd3, 16'h0000);
        @(posedge clk); #2;
        check("R10 clk_out free-runs again", 32'(clk_out), 1);
    endtask

    task automatic t_standby;
        logic [15:0] v;
        wr(2'd1, 16'h0000);
        check("R5 writing 0 leaves clock running", 32'(core_clk_en), 1);
        wr(2'd1, 16'h8000);
        rd(2'd1, v);
        check("R5 flag reads set", 32'(v), 32'h8000);
        check("R5 clock runs at drain start", 32'(core_clk_en), 1);
        @(negedge clk); #1;
        check("R5 clock runs during drain", 32'(core_clk_en), 1);
        @(negedge clk); #1;
        check("R5 clock runs to last drain cycle", 32'(core_clk_en), 1);
        @(negedge clk); #1;
        check("R5 clock stopped after drain", 32'(core_clk_en), 0);
        @(posedge clk); #2;
        check("R6 core_clk held low while asleep", 32'(core_clk), 0);
    endtask

    task automatic t_wake;
        logic [15:0] v;
        @(negedge clk); #1;
        irq_pend = 8'h04; irq_en = 8'h02; irq_glob_en = 1'b1;
        repeat (3) @(negedge clk); #1;
        check("R7 pending line not enabled keeps sleep", 32'(core_clk_en), 0);
        irq_en = 8'h04; irq_glob_en = 1'b0;
        repeat (3) @(negedge clk); #1;
        check("R7 global disable keeps sleep", 32'(core_clk_en), 0);
        check("R7 no vector while asleep", 32'(irq_vec), 0);
        rd(2'd1, v);
        check("R7 flag still set", 32'(v), 32'h8000);
        irq_glob_en = 1'b1;
        @(negedge clk); #1;
        check("R8 clock resumes", 32'(core_clk_en), 1);
        check("R8 vector strobe", 32'(irq_vec), 1);
        rd(2'd1, v);
        check("R8 flag auto-cleared", 32'(v), 0);
        irq_pend = '0;
        @(negedge clk); #1;
        check("R8 vector lasts one cycle", 32'(irq_vec), 0);
        check("R8 clock keeps running", 32'(core_clk_en), 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_pll();
        t_lock_loss();
        t_power();
        t_clkout();
        t_standby();
        t_wake();
        done = 1'b1;
        finish_run();
    end
endmodule